// File: doc/BRIEF.md
# Converter Power-State and Calibration Sequencer

This block is the control state machine that decides when a mixed-signal converter is powered down, calibrating its offset, or running. It runs from a free-running internal timebase clock (`clk`). Every interval it enforces is a parameter counted in ticks of that clock. The analog calibration is modelled only as a timed window.

The reset pin `rst_n` is active low and acts asynchronously. While it is low, the device is held powered down and the control-register reset strobe is high. When `rst_n` is released, the sequencer runs an automatic offset calibration and then enables the datapath. In normal operation, three conditions force power-down:
- a master clock that stays silent too long;
- a frame clock that is out of step with the master clock;
- a low supply.

A low supply also mutes the outputs at once. These fault-driven power-downs keep the control settings. When the fault clears, a new calibration runs before the datapath is enabled again.

Software can request a recalibration by writing a command bit. That bit clears itself when the calibration begins. A write made while a calibration is already running is discarded.

Top module: `pwr_cal_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are held, without waiting for a clock edge, at: `pwr_down`=1, `cal_busy`=0, `run`=0, `mute`=1, `ctrl_rst`=1 and `cal_pending`=0.
- R2: `ctrl_rst` falls at the first `clk` edge after `rst_n` is released. It stays 0 until `rst_n` goes low again, including through every fault-driven power-down.
- R3: After reset release with no fault present, `cal_busy` is 1 from the first edge for exactly CAL_CYC cycles. At the next edge `run` rises.
- R4: A one-cycle pulse on `cal_wr` while running sets `cal_pending` at the next edge. One edge later a calibration of CAL_CYC cycles starts, and at that moment `cal_pending` returns to 0. A write during power-down is held in `cal_pending` until the recovery calibration starts.
- R5: A `cal_wr` pulse during a calibration leaves `cal_pending` at 0, does not stretch the calibration, and starts no second one.
- R6: Once `mclk_active` has been sampled low at LOSS_CYC consecutive edges, `pwr_down` rises at the following edge. A run of LOSS_CYC-1 low samples has no effect.
- R7: `frame_sync_ok` sampled low at an edge makes `pwr_down` 1 after that edge.
- R8: `supply_low` sets `mute` within the same cycle, with no clock edge needed. If it is sampled high at an edge, `pwr_down` is 1 after that edge.
- R9: In power-down with no fault present, the next edge starts a calibration, and `run` rises CAL_CYC cycles later.
- R10: Exactly one of `pwr_down`, `cal_busy` and `run` is high at any time.
- R11: A fault during a calibration abandons it: `pwr_down` is 1 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal timebase clock |
| rst_n | input | 1 | Active-low reset pin, asynchronous |
| mclk_active | input | 1 | High in a tick where master-clock activity was seen |
| frame_sync_ok | input | 1 | High while the frame clock is in step with the master clock |
| supply_low | input | 1 | Supply undervoltage flag |
| cal_wr | input | 1 | Software write of the calibration command bit |
| pwr_down | output | 1 | Power-down enable |
| mute | output | 1 | Output mute enable |
| cal_busy | output | 1 | Read-only status: calibration in progress |
| cal_pending | output | 1 | Calibration command bit as seen by software |
| ctrl_rst | output | 1 | Control-register reset strobe |
| run | output | 1 | Datapath run enable |

## Verification
The fault inputs are applied from the running state one pattern at a time:
- master-clock silence just below the loss limit and just at it;
- loss of frame sync alone;
- undervoltage held for zero edges and for one edge;
- a combination of faults;
- a quiet pattern with no fault.

These patterns separate a filtered clock loss from an immediate one, immediate muting from clocked power-down, and a fault that forces recalibration from one that leaves the run state untouched. The recovery delay is then measured for each pattern, which exposes the extra cycle that the saturated clock-loss counter adds. Directed sequences cover software requests in each state and the abandonment of a calibration.

// File: rtl/pwr_cal_pkg.sv
package pwr_cal_pkg;

  typedef enum logic [1:0] {
    ST_PDN = 2'd0,
    ST_CAL = 2'd1,
    ST_RUN = 2'd2
  } seq_state_e;

  // Bits needed to hold values 0..n
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Any condition that forces power-down
  function automatic logic any_fault(input logic lost, input logic sync_ok, input logic uv);
    return lost | ~sync_ok | uv;
  endfunction

endpackage

// File: rtl/pcs_clk_monitor.sv
module pcs_clk_monitor #(
  parameter int unsigned LOSS_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_active,
  output logic clk_lost
);
  localparam int unsigned W = pwr_cal_pkg::cnt_w(LOSS_CYC);

  logic [W-1:0] idle_q;

  // Count consecutive silent ticks, saturating at the loss limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      idle_q <= '0;
    else if (mclk_active)            idle_q <= '0;
    else if (idle_q != W'(LOSS_CYC)) idle_q <= idle_q + 1'b1;
  end

  assign clk_lost = (idle_q == W'(LOSS_CYC));
endmodule

// File: rtl/pcs_cal_timer.sv
module pcs_cal_timer #(
  parameter int unsigned CAL_CYC = 2400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic done
);
  localparam int unsigned W = pwr_cal_pkg::cnt_w(CAL_CYC);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (start)  cnt_q <= '0;
    else if (active) cnt_q <= cnt_q + 1'b1;
  end

  // Last tick of the window
  assign done = active && (cnt_q == W'(CAL_CYC - 1));
endmodule

// File: rtl/pwr_cal_seq.sv
module pwr_cal_seq #(
  parameter int unsigned CAL_CYC  = 2400,
  parameter int unsigned LOSS_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_active,
  input  logic frame_sync_ok,
  input  logic supply_low,
  input  logic cal_wr,
  output logic pwr_down,
  output logic mute,
  output logic cal_busy,
  output logic cal_pending,
  output logic ctrl_rst,
  output logic run
);
  import pwr_cal_pkg::*;

  seq_state_e state_q, state_d;
  logic clk_lost;
  logic fault;
  logic cal_done;
  logic cal_start;
  logic pend_q;
  logic ctrl_rst_q;

  pcs_clk_monitor #(.LOSS_CYC(LOSS_CYC)) u_mon (
    .clk         (clk),
    .rst_n       (rst_n),
    .mclk_active (mclk_active),
    .clk_lost    (clk_lost)
  );

  pcs_cal_timer #(.CAL_CYC(CAL_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (cal_start),
    .active (state_q == ST_CAL),
    .done   (cal_done)
  );

  assign fault = any_fault(clk_lost, frame_sync_ok, supply_low);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PDN: if (!fault) state_d = ST_CAL;
      ST_CAL: begin
        if (fault)         state_d = ST_PDN;
        else if (cal_done) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (fault)       state_d = ST_PDN;
        else if (pend_q) state_d = ST_CAL;
      end
      default: state_d = ST_PDN;
    endcase
  end

  assign cal_start = (state_d == ST_CAL) && (state_q != ST_CAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PDN;
    else        state_q <= state_d;
  end

  // Self-clearing command bit; writes during calibration are dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             pend_q <= 1'b0;
    else if (cal_start)                     pend_q <= 1'b0;
    else if (cal_wr && state_q != ST_CAL)   pend_q <= 1'b1;
  end

  // Defaults strobe: only the reset pin raises it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_rst_q <= 1'b1;
    else        ctrl_rst_q <= 1'b0;
  end

  assign pwr_down    = (state_q == ST_PDN);
  assign cal_busy    = (state_q == ST_CAL);
  assign run         = (state_q == ST_RUN);
  assign mute        = supply_low | (state_q != ST_RUN);
  assign cal_pending = pend_q;
  assign ctrl_rst    = ctrl_rst_q;
endmodule

// File: rtl/pwr_cal_seq_chk.sv
module pwr_cal_seq_chk #(
  parameter int unsigned CAL_CYC = 2400
) (
  input logic clk,
  input logic rst_n,
  input logic frame_sync_ok,
  input logic supply_low,
  input logic clk_lost,
  input logic pwr_down,
  input logic mute,
  input logic cal_busy,
  input logic cal_pending,
  input logic ctrl_rst,
  input logic run
);
  localparam int unsigned LW = pwr_cal_pkg::cnt_w(CAL_CYC) + 1;

  logic [LW-1:0] len_q;

  // Length of the current run of calibration cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         len_q <= '0;
    else if (!cal_busy)                 len_q <= '0;
    else if (len_q != {LW{1'b1}})       len_q <= len_q + 1'b1;
  end

  p_one_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({pwr_down, cal_busy, run}));

  p_defaults_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rst |=> !ctrl_rst);

  p_cal_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ($past(cal_busy) && len_q == LW'(CAL_CYC)));

  p_cmd_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_busy) |-> !cal_pending);

  p_busy_drops_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> !cal_pending);

  p_clk_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_lost |=> pwr_down);

  p_sync_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync_ok |=> pwr_down);

  p_uv_mute_r8: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |-> mute);

  p_uv_pdn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> pwr_down);

  p_recover_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && !clk_lost && frame_sync_ok && !supply_low) |=> cal_busy);

  p_abandon_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && (clk_lost || !frame_sync_ok || supply_low)) |=> pwr_down);
endmodule

bind pwr_cal_seq pwr_cal_seq_chk #(.CAL_CYC(CAL_CYC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_sync_ok (frame_sync_ok),
  .supply_low    (supply_low),
  .clk_lost      (clk_lost),
  .pwr_down      (pwr_down),
  .mute          (mute),
  .cal_busy      (cal_busy),
  .cal_pending   (cal_pending),
  .ctrl_rst      (ctrl_rst),
  .run           (run)
);

// File: tb/pwr_cal_seq_test.sv
`timescale 1ns/1ps
module pwr_cal_seq_test;
  localparam int unsigned CAL  = 12;
  localparam int unsigned LOSS = 4;

  logic clk = 1'b0;
  logic rst_n, mclk_active, frame_sync_ok, supply_low, cal_wr;
  logic pwr_down, mute, cal_busy, cal_pending, ctrl_rst, run;

  int checks = 0;
  int errors = 0;
  int onehot_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_cal_seq #(.CAL_CYC(CAL), .LOSS_CYC(LOSS)) uut (
    .clk(clk), .rst_n(rst_n), .mclk_active(mclk_active),
    .frame_sync_ok(frame_sync_ok), .supply_low(supply_low), .cal_wr(cal_wr),
    .pwr_down(pwr_down), .mute(mute), .cal_busy(cal_busy),
    .cal_pending(cal_pending), .ctrl_rst(ctrl_rst), .run(run)
  );

  typedef struct packed {
    logic       mclk;
    logic       sync;
    logic       uv;
    logic [3:0] hold;
    logic       pdn;
    logic       mte;
    logic [1:0] rec;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VT [NV] = '{
    '{1'b0, 1'b1, 1'b0, 4'd3, 1'b0, 1'b0, 2'd1},   // R6 below limit
    '{1'b0, 1'b1, 1'b0, 4'd5, 1'b1, 1'b1, 2'd2},   // R6 loss
    '{1'b1, 1'b0, 1'b0, 4'd1, 1'b1, 1'b1, 2'd1},   // R7
    '{1'b1, 1'b1, 1'b1, 4'd0, 1'b0, 1'b1, 2'd1},   // R8 immediate mute
    '{1'b1, 1'b1, 1'b1, 4'd1, 1'b1, 1'b1, 2'd1},   // R8 power-down
    '{1'b0, 1'b0, 1'b1, 4'd2, 1'b1, 1'b1, 2'd1},   // combined
    '{1'b1, 1'b1, 1'b0, 4'd3, 1'b0, 1'b0, 2'd1}    // quiet
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic benign();
    mclk_active = 1'b1; frame_sync_ok = 1'b1; supply_low = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk)
    if (rst_n && ($countones({pwr_down, cal_busy, run}) != 1)) onehot_bad++;

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cal_wr = 1'b0; benign();
    edges(3);
    // R1 reset state
    chk("R1 pwr_down", pwr_down, 1); chk("R1 cal_busy", cal_busy, 0);
    chk("R1 run", run, 0);           chk("R1 mute", mute, 1);
    chk("R1 ctrl_rst", ctrl_rst, 1); chk("R1 cal_pending", cal_pending, 0);
    rst_n = 1'b1;
    edges(1);
    chk("R2 ctrl_rst low", ctrl_rst, 0); chk("R3 cal starts", cal_busy, 1);
    edges(CAL - 1);
    chk("R3 still busy at last cycle", cal_busy, 1);
    edges(1);
    chk("R3 run after cal", run, 1);

    // Table of fault patterns from the running state
    for (int i = 0; i < NV; i++) begin
      mclk_active = VT[i].mclk; frame_sync_ok = VT[i].sync; supply_low = VT[i].uv;
      if (VT[i].hold == 0) #1;
      else edges(int'(VT[i].hold));
      chk($sformatf("R6/R7/R8 vec%0d pwr_down", i), pwr_down, VT[i].pdn);
      chk($sformatf("R8 vec%0d mute", i), mute, VT[i].mte);
      benign();
      if (VT[i].pdn) begin
        edges(int'(VT[i].rec));
        chk($sformatf("R9 vec%0d recal", i), cal_busy, 1);
        edges(CAL);
        chk($sformatf("R9 vec%0d run", i), run, 1);
        chk($sformatf("R9 vec%0d settings kept", i), ctrl_rst, 0);
      end else begin
        edges(1);
        chk($sformatf("R6 vec%0d still run", i), run, 1);
        chk($sformatf("R8 vec%0d unmuted", i), mute, 0);
      end
    end

    // R4 software request while running
    cal_wr = 1'b1; edges(1); cal_wr = 1'b0;
    chk("R4 pending set", cal_pending, 1); chk("R4 still run", run, 1);
    edges(1);
    chk("R4 cal started", cal_busy, 1); chk("R4 pending cleared", cal_pending, 0);
    // R5 request during calibration ignored
    cal_wr = 1'b1; edges(1); cal_wr = 1'b0;
    chk("R5 pending stays low", cal_pending, 0);
    edges(CAL - 2);
    chk("R5 busy at last cycle", cal_busy, 1);
    edges(1);
    chk("R5 run on time", run, 1);
    edges(1);
    chk("R5 no second cal", run, 1);

    // R11 abandon, request held in power-down
    cal_wr = 1'b1; edges(1); cal_wr = 1'b0;
    edges(1);
    chk("R11 cal running", cal_busy, 1);
    frame_sync_ok = 1'b0; edges(1);
    chk("R11 abandoned", pwr_down, 1);
    cal_wr = 1'b1; edges(1); cal_wr = 1'b0;
    chk("R4 pending held in pdn", cal_pending, 1);
    frame_sync_ok = 1'b1; edges(1);
    chk("R9 recal", cal_busy, 1); chk("R4 pending cleared on recal", cal_pending, 0);
    edges(CAL);
    chk("R9 run", run, 1);

    // R6 exact boundary
    mclk_active = 1'b0; edges(LOSS);
    chk("R6 not yet down", pwr_down, 0);
    edges(1);
    chk("R6 down", pwr_down, 1);
    benign(); edges(2);
    chk("R6 recal", cal_busy, 1);
    edges(CAL);
    chk("R6 run", run, 1);

    // R1 asynchronous reset from running
    rst_n = 1'b0; #1;
    chk("R1 async pwr_down", pwr_down, 1); chk("R1 async ctrl_rst", ctrl_rst, 1);
    chk("R10 onehot", onehot_bad, 0);
    finish_run();
  end
endmodule